// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns one memory-operand request into a linear address for a segmented 32-bit machine. A request carries a base register value, an index register value, a 2-bit scale code, a displacement with a size code, a 16-bit segment selector and the current privilege level. The block adds base, scaled index and displacement to form the effective offset. It then looks up the descriptor that the selector names, checks the offset and the privilege against that descriptor, and adds the segment base. The result is either a linear address or a fault code.

The path has two pipeline stages. The first stage forms the offset. The second stage reads the descriptor and does the checks and the segment add. Both the request side and the result side use a valid/ready handshake. The descriptors sit in a register array with two banks, one for the global table and one for the local table. Each bank holds `2**IDX_W` entries and is loaded through a one-entry-per-cycle write port.

Top module: `seg_agu`

## Requirements
- R1: The effective offset is (base if base valid, else 0) + ((index if index valid, else 0) << scale code) + extended displacement, with every sum taken modulo 2^32. Scale codes 0, 1, 2 and 3 mean factors of 1, 2, 4 and 8.
- R2: The displacement size code selects the displacement. Code 0 gives zero. Code 1 gives bits [7:0] sign-extended to 32 bits. Code 2 gives all 32 bits. Code 3 gives zero.
- R3: The selector is decoded as index = sel[15:3], table = sel[2] (0 global, 1 local) and requested level = sel[1:0].
- R4: A result without a fault carries linear = descriptor base + effective offset (mod 2^32). A result with a fault carries linear = 0.
- R5: When all earlier checks pass and the offset is greater than the descriptor limit, the fault code is 3 (limit).
- R6: When the descriptor is present and max(CPL, requested level) is numerically greater than the descriptor level, the fault code is 2 (privilege). Level 0 is the most privileged. This check takes priority over the limit check.
- R7: A global-table selector with index 0 gives fault code 1 (null). This fault takes priority over all other faults. A local-table selector with index 0 is an ordinary entry.
- R8: A non-null selector whose index is at least 2**IDX_W gives fault code 4 (range). When the index is in range and the entry's present bit is 0, the fault code is 5 (absent). Range takes priority over absent, and absent takes priority over privilege.
- R9: A request accepted on a clock edge produces its result as out_valid on the next edge. While out_valid is high and out_ready is low, out_linear and out_fault stay stable. in_ready is low only when both stages hold data and out_ready is low. Results leave in the order their requests were accepted.
- R10: After a synchronous reset, out_valid is 0, in_ready is 1 and every descriptor is not present.
- R11: A descriptor written on a clock edge is used by every request accepted on that edge or later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_base | input | 32 | Base register value |
| in_base_v | input | 1 | Base operand present |
| in_index | input | 32 | Index register value |
| in_index_v | input | 1 | Index operand present |
| in_scale | input | 2 | Scale code (shift amount) |
| in_disp | input | 32 | Displacement bits |
| in_disp_sz | input | 2 | Displacement size code |
| in_sel | input | 16 | Segment selector |
| in_cpl | input | 2 | Current privilege level |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_linear | output | 32 | Linear address, 0 on a fault |
| out_fault | output | 3 | Fault code (0 none, 1 null, 2 privilege, 3 limit, 4 range, 5 absent) |
| dt_we | input | 1 | Descriptor write enable |
| dt_ti | input | 1 | Written table (0 global, 1 local) |
| dt_idx | input | IDX_W | Written entry number |
| dt_base | input | 32 | Written segment base |
| dt_limit | input | 32 | Written segment limit |
| dt_present | input | 1 | Written present bit |
| dt_dpl | input | 2 | Written descriptor privilege level |

## Verification
Several corner cases get direct checks. The bench drives base and index values that push the sum past 2^32: a design that dropped the wrap or shifted by the wrong amount would give a wrong linear address. Byte displacements with bit 7 set would come out 256 too large if the sign extension were missing. The bench sweeps selectors over both tables and over indices above the table size, every requested level and CPL pairing, and offsets exactly at the limit and one past it. An off-by-one limit compare, a swapped table bit, a null check applied to the local table, or a wrong fault priority would each show up as a wrong fault code. A back-pressure run fills both stages. A design that lost a result, reordered results or changed a held output would give a wrong value or a wrong in_ready.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;

    localparam int AW     = 32;
    localparam int SEL_W  = 16;
    localparam int SIDX_W = 13;
    localparam int FLT_W  = 3;

    typedef enum logic [FLT_W-1:0] {
        FLT_NONE   = 3'd0,
        FLT_NULL   = 3'd1,
        FLT_PRIV   = 3'd2,
        FLT_LIMIT  = 3'd3,
        FLT_RANGE  = 3'd4,
        FLT_ABSENT = 3'd5
    } fault_e;

    typedef enum logic [1:0] {
        DSP_NONE = 2'd0,
        DSP_BYTE = 2'd1,
        DSP_WORD = 2'd2,
        DSP_RSVD = 2'd3
    } disp_sz_e;

    // Field order is behaviour: index in [15:3], table bit [2], level [1:0].
    typedef struct packed {
        logic [SIDX_W-1:0] idx;
        logic              ti;
        logic [1:0]        rpl;
    } sel_t;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] limit;
        logic          present;
        logic [1:0]    dpl;
    } desc_t;

    typedef struct packed {
        logic [AW-1:0] off;
        sel_t          sel;
        logic [1:0]    cpl;
    } stage1_t;

    function automatic logic [AW-1:0] ext_disp(input logic [AW-1:0] d,
                                               input disp_sz_e sz);
        case (sz)
            DSP_BYTE: ext_disp = {{(AW-8){d[7]}}, d[7:0]};
            DSP_WORD: ext_disp = d;
            default:  ext_disp = '0;
        endcase
    endfunction

    function automatic logic [1:0] weaker_level(input logic [1:0] a,
                                                input logic [1:0] b);
        weaker_level = (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seg_agu_offset.sv
module seg_agu_offset
    import seg_agu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [AW-1:0] base,
    input  logic          base_v,
    input  logic [AW-1:0] index,
    input  logic          index_v,
    input  logic [1:0]    scale,
    input  logic [AW-1:0] disp,
    input  logic [1:0]    disp_sz,
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]    cpl,
    input  logic          advance,
    output logic          s1_valid,
    output stage1_t       s1
);

    logic [AW-1:0] base_term;
    logic [AW-1:0] index_term;
    logic [AW-1:0] disp_term;
    logic [AW-1:0] off_c;
    logic          take;

    always_comb begin
        base_term  = base_v ? base : '0;
        index_term = (index_v ? index : '0) << scale;
        disp_term  = ext_disp(disp, disp_sz_e'(disp_sz));
        off_c      = base_term + index_term + disp_term;
    end

    assign in_ready = !s1_valid || advance;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1       <= '0;
        end else if (in_ready) begin
            s1_valid <= in_valid;
            if (take) begin
                s1.off <= off_c;
                s1.sel <= sel_t'(sel);
                s1.cpl <= cpl;
            end
        end
    end

    // R1/R2: with no operand and no displacement the offset is zero
    a_r1_empty_operands_zero: assert property (@(posedge clk) disable iff (rst)
        (take && !base_v && !index_v && (disp_sz == 2'd0 || disp_sz == 2'd3))
        |=> (s1_valid && s1.off == '0));

    // R9: an accepted request occupies stage one on the next edge
    a_r9_accept_fills: assert property (@(posedge clk) disable iff (rst)
        take |=> s1_valid);

endmodule

// File: rtl/seg_agu_desc_tab.sv
module seg_agu_desc_tab
    import seg_agu_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             w_ti,
    input  logic [IDX_W-1:0] w_idx,
    input  desc_t            w_desc,
    input  logic             r_ti,
    input  logic [IDX_W-1:0] r_idx,
    output desc_t            r_desc
);

    localparam int ENTRIES = 1 << IDX_W;
    localparam int BANKS   = 2;

    desc_t bank_q [BANKS][ENTRIES];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
            always_ff @(posedge clk) begin
                if (rst) begin
                    bank_q[b][e] <= '0;
                end else if (we && (w_ti == 1'(b)) && (w_idx == IDX_W'(e))) begin
                    bank_q[b][e] <= w_desc;
                end
            end
        end
    end

    // Write-through so a write on the same edge as the read is seen.
    always_comb begin
        if (we && (w_ti == r_ti) && (w_idx == r_idx)) begin
            r_desc = w_desc;
        end else begin
            r_desc = bank_q[r_ti][r_idx];
        end
    end

endmodule

// File: rtl/seg_agu_check.sv
module seg_agu_check
    import seg_agu_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             s1_valid,
    input  stage1_t          s1,
    input  desc_t            desc,
    input  logic             out_ready,
    output logic             advance,
    output logic             out_valid,
    output logic [AW-1:0]    out_linear,
    output logic [FLT_W-1:0] out_fault
);

    fault_e        fault_c;
    logic [AW-1:0] lin_c;
    logic          idx_high;
    logic          is_null;
    logic [1:0]    eff_pl;

    always_comb begin
        idx_high = (s1.sel.idx >> IDX_W) != '0;
        is_null  = !s1.sel.ti && (s1.sel.idx == '0);
        eff_pl   = weaker_level(s1.cpl, s1.sel.rpl);
        if (is_null)                 fault_c = FLT_NULL;
        else if (idx_high)           fault_c = FLT_RANGE;
        else if (!desc.present)      fault_c = FLT_ABSENT;
        else if (eff_pl > desc.dpl)  fault_c = FLT_PRIV;
        else if (s1.off > desc.limit) fault_c = FLT_LIMIT;
        else                         fault_c = FLT_NONE;
        lin_c = (fault_c == FLT_NONE) ? (desc.base + s1.off) : '0;
    end

    assign advance = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_linear <= '0;
            out_fault  <= '0;
        end else if (advance) begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_linear <= lin_c;
                out_fault  <= fault_c;
            end
        end
    end

    // R5: a clean result never exceeds the limit
    always_comb begin
        if (!rst && s1_valid && fault_c == FLT_NONE) begin
            a_r5_clean_within_limit: assert (s1.off <= desc.limit);
        end
    end

    // R9: held result stays stable under back-pressure
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_linear) && $stable(out_fault)));

    // R4: faulted results carry a zero address
    a_r4_fault_zero_linear: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fault != '0) |-> (out_linear == '0));

    // R10: reset empties the output stage
    a_r10_reset_empty: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R7/R8: only defined fault codes appear
    a_r8_code_defined: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_fault <= 3'd5));

endmodule

// File: rtl/seg_agu.sv
module seg_agu
    import seg_agu_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [31:0]      in_base,
    input  logic             in_base_v,
    input  logic [31:0]      in_index,
    input  logic             in_index_v,
    input  logic [1:0]       in_scale,
    input  logic [31:0]      in_disp,
    input  logic [1:0]       in_disp_sz,
    input  logic [15:0]      in_sel,
    input  logic [1:0]       in_cpl,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [31:0]      out_linear,
    output logic [2:0]       out_fault,
    input  logic             dt_we,
    input  logic             dt_ti,
    input  logic [IDX_W-1:0] dt_idx,
    input  logic [31:0]      dt_base,
    input  logic [31:0]      dt_limit,
    input  logic             dt_present,
    input  logic [1:0]       dt_dpl
);

    logic    s1_valid;
    stage1_t s1;
    logic    advance;
    desc_t   w_desc;
    desc_t   r_desc;

    assign w_desc = '{base: dt_base, limit: dt_limit, present: dt_present, dpl: dt_dpl};

    seg_agu_offset u_offset (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .base     (in_base),
        .base_v   (in_base_v),
        .index    (in_index),
        .index_v  (in_index_v),
        .scale    (in_scale),
        .disp     (in_disp),
        .disp_sz  (in_disp_sz),
        .sel      (in_sel),
        .cpl      (in_cpl),
        .advance  (advance),
        .s1_valid (s1_valid),
        .s1       (s1)
    );

    seg_agu_desc_tab #(.IDX_W(IDX_W)) u_tab (
        .clk    (clk),
        .rst    (rst),
        .we     (dt_we),
        .w_ti   (dt_ti),
        .w_idx  (dt_idx),
        .w_desc (w_desc),
        .r_ti   (s1.sel.ti),
        .r_idx  (s1.sel.idx[IDX_W-1:0]),
        .r_desc (r_desc)
    );

    seg_agu_check #(.IDX_W(IDX_W)) u_check (
        .clk        (clk),
        .rst        (rst),
        .s1_valid   (s1_valid),
        .s1         (s1),
        .desc       (r_desc),
        .out_ready  (out_ready),
        .advance    (advance),
        .out_valid  (out_valid),
        .out_linear (out_linear),
        .out_fault  (out_fault)
    );

    // R10: an empty pipeline always accepts
    a_r10_ready_when_empty: assert property (@(posedge clk) disable iff (rst)
        (!s1_valid && !out_valid) |-> in_ready);

endmodule

// File: tb/seg_agu_bench.sv
module seg_agu_bench;

    localparam int IDX_W = 2;
    localparam int NENT  = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid;
    logic             in_ready;
    logic [31:0]      in_base;
    logic             in_base_v;
    logic [31:0]      in_index;
    logic             in_index_v;
    logic [1:0]       in_scale;
    logic [31:0]      in_disp;
    logic [1:0]       in_disp_sz;
    logic [15:0]      in_sel;
    logic [1:0]       in_cpl;
    logic             out_valid;
    logic             out_ready;
    logic [31:0]      out_linear;
    logic [2:0]       out_fault;
    logic             dt_we;
    logic             dt_ti;
    logic [IDX_W-1:0] dt_idx;
    logic [31:0]      dt_base;
    logic [31:0]      dt_limit;
    logic             dt_present;
    logic [1:0]       dt_dpl;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] m_base  [2][NENT];
    logic [31:0] m_limit [2][NENT];
    logic        m_pres  [2][NENT];
    logic [1:0]  m_dpl   [2][NENT];

    always #10 clk = ~clk;

    seg_agu #(.IDX_W(IDX_W)) u_seg_agu (.*);

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    function automatic logic [31:0] exp_off(logic [31:0] b, logic bv, logic [31:0] x,
                                            logic xv, logic [1:0] sc, logic [31:0] d,
                                            logic [1:0] dsz);
        logic [31:0] dd;
        logic [31:0] t;
        case (dsz)
            2'd1: dd = d[7] ? (32'hFFFF_FF00 | {24'd0, d[7:0]}) : {24'd0, d[7:0]};
            2'd2: dd = d;
            default: dd = 32'd0;
        endcase
        t = xv ? x * (32'd1 << sc) : 32'd0;
        return (bv ? b : 32'd0) + t + dd;
    endfunction

    task automatic exp_result(input logic [15:0] sel, input logic [1:0] cpl,
                              input logic [31:0] off,
                              output logic [2:0] f, output logic [31:0] lin);
        int idx;
        int ti;
        int rpl;
        int pl;
        idx = int'(sel >> 3);
        ti  = int'(sel[2]);
        rpl = int'(sel[1:0]);
        pl  = (int'(cpl) > rpl) ? int'(cpl) : rpl;
        if (ti == 0 && idx == 0)                f = 3'd1;
        else if (idx >= NENT)                   f = 3'd4;
        else if (!m_pres[ti][idx])              f = 3'd5;
        else if (pl > int'(m_dpl[ti][idx]))     f = 3'd2;
        else if (off > m_limit[ti][idx])        f = 3'd3;
        else                                    f = 3'd0;
        lin = (f == 3'd0) ? m_base[ti][idx] + off : 32'd0;
    endtask

    task automatic write_desc(input logic ti, input int idx, input logic [31:0] b,
                              input logic [31:0] l, input logic p, input logic [1:0] d);
        @(negedge clk);
        dt_we = 1'b1; dt_ti = ti; dt_idx = IDX_W'(idx);
        dt_base = b; dt_limit = l; dt_present = p; dt_dpl = d;
        m_base[ti][idx] = b; m_limit[ti][idx] = l; m_pres[ti][idx] = p; m_dpl[ti][idx] = d;
        @(negedge clk);
        dt_we = 1'b0;
    endtask

    task automatic drive(input logic [31:0] b, input logic bv, input logic [31:0] x,
                         input logic xv, input logic [1:0] sc, input logic [31:0] d,
                         input logic [1:0] dsz, input logic [15:0] sel, input logic [1:0] cpl);
        in_valid = 1'b1; in_base = b; in_base_v = bv; in_index = x; in_index_v = xv;
        in_scale = sc; in_disp = d; in_disp_sz = dsz; in_sel = sel; in_cpl = cpl;
    endtask

    // One request with out_ready high; result sampled one edge after acceptance.
    task automatic one_req(input string req, input logic [31:0] b, input logic bv,
                           input logic [31:0] x, input logic xv, input logic [1:0] sc,
                           input logic [31:0] d, input logic [1:0] dsz,
                           input logic [15:0] sel, input logic [1:0] cpl);
        logic [31:0] off;
        logic [2:0]  ef;
        logic [31:0] el;
        @(negedge clk);
        drive(b, bv, x, xv, sc, d, dsz, sel, cpl);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        off = exp_off(b, bv, x, xv, sc, d, dsz);
        exp_result(sel, cpl, off, ef, el);
        check("R9", "latency out_valid", 32'(out_valid), 32'd1);
        check(req, "fault", 32'(out_fault), 32'(ef));
        check(req, "linear", out_linear, el);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; dt_we = 1'b0;
        dt_ti = 1'b0; dt_idx = '0; dt_base = '0; dt_limit = '0; dt_present = 1'b0; dt_dpl = '0;
        drive(32'd0, 1'b0, 32'd0, 1'b0, 2'd0, 32'd0, 2'd0, 16'd0, 2'd0);
        in_valid = 1'b0;
        for (int t = 0; t < 2; t++) begin
            for (int e = 0; e < NENT; e++) begin
                m_base[t][e] = '0; m_limit[t][e] = '0; m_pres[t][e] = 1'b0; m_dpl[t][e] = '0;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        check("R10", "out_valid after reset", 32'(out_valid), 32'd0);
        check("R10", "in_ready after reset", 32'(in_ready), 32'd1);
        one_req("R10", 32'd0, 1'b1, 32'd0, 1'b0, 2'd0, 32'd0, 2'd0, {13'd1, 1'b1, 2'd0}, 2'd0);

        // R11: write then request right away
        write_desc(1'b1, 0, 32'h1000_0000, 32'hFFFF_FFFF, 1'b1, 2'd3);
        one_req("R11", 32'h20, 1'b1, 32'd0, 1'b0, 2'd0, 32'd0, 2'd0, {13'd0, 1'b1, 2'd3}, 2'd3);

        write_desc(1'b0, 1, 32'h0001_0000, 32'h0000_0FFF, 1'b1, 2'd0);
        write_desc(1'b0, 2, 32'hFFFF_F000, 32'h0000_2000, 1'b1, 2'd2);
        write_desc(1'b0, 3, 32'h5555_0000, 32'h0000_1000, 1'b0, 2'd3);
        write_desc(1'b1, 1, 32'h0000_0100, 32'h0000_0000, 1'b1, 2'd1);
        write_desc(1'b1, 2, 32'h0F00_0000, 32'h7FFF_FFFF, 1'b1, 2'd3);
        write_desc(1'b1, 3, 32'h0000_0000, 32'h0000_0010, 1'b1, 2'd2);

        // R1/R2/R4: operand and displacement sweep through local entry 0
        for (int sc = 0; sc < 4; sc++)
            for (int dz = 0; dz < 4; dz++)
                for (int m = 0; m < 4; m++)
                    for (int dv = 0; dv < 2; dv++)
                        one_req(dz == 1 ? "R2" : "R1", 32'h8000_0013, m[0], 32'h4000_0007, m[1],
                                2'(sc), dv ? 32'h1234_56F0 : 32'h0000_0070, 2'(dz),
                                {13'd0, 1'b1, 2'd1}, 2'd0);

        // R3/R5/R6/R7/R8: selector, level and limit sweep
        for (int ti = 0; ti < 2; ti++)
            for (int ix = 0; ix < 8; ix++)
                for (int rp = 0; rp < 4; rp++)
                    for (int cp = 0; cp < 4; cp++)
                        for (int k = 0; k < 2; k++) begin
                            logic [31:0] lim;
                            lim = (ix < NENT) ? m_limit[ti][ix] : 32'd0;
                            one_req(ti == 0 && ix == 0 ? "R7" : (ix >= NENT ? "R8" :
                                    (k == 1 ? "R5" : (rp != cp ? "R6" : "R3"))),
                                    lim + 32'(k), 1'b1, 32'd0, 1'b0, 2'd0, 32'd0, 2'd0,
                                    {13'(ix), 1'(ti), 2'(rp)}, 2'(cp));
                        end

        // R9: back-pressure, ordering and stability
        begin
            logic [31:0] el [3];
            logic [2:0]  ef [3];
            for (int i = 0; i < 3; i++)
                exp_result({13'd0, 1'b1, 2'd0}, 2'd0, 32'(i * 16 + 4), ef[i], el[i]);
            @(negedge clk);
            out_ready = 1'b0;
            for (int i = 0; i < 3; i++) begin
                drive(32'(i * 16 + 4), 1'b1, 32'd0, 1'b0, 2'd0, 32'd0, 2'd0, {13'd0, 1'b1, 2'd0}, 2'd0);
                if (i < 2) @(negedge clk);
            end
            check("R9", "in_ready with both stages full", 32'(in_ready), 32'd0);
            repeat (4) begin
                @(negedge clk);
                check("R9", "held linear", out_linear, el[0]);
            end
            check("R9", "in_ready still low", 32'(in_ready), 32'd0);
            out_ready = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            for (int i = 1; i < 3; i++) begin
                check("R9", "ordered valid", 32'(out_valid), 32'd1);
                check("R9", "ordered linear", out_linear, el[i]);
                check("R9", "ordered fault", 32'(out_fault), 32'(ef[i]));
                @(negedge clk);
            end
            check("R9", "drained", 32'(out_valid), 32'd0);
        end

        done = 1'b1;
        finish_run();
    end

endmodule